// File: doc/BRIEF.md
# Dual-Channel Sweep Peak Tracker

This block is the digital controller for a frequency-shift readout. It steps a frequency code across a programmed range, and that code drives an external oscillator or DAC. One excitation sweep reaches two sensors at the same time: a test channel and a control channel. For each code, the block waits a programmed settling time. It then takes one digitized amplitude reading from each channel. For each channel it keeps the code at which the amplitude was largest.

When the sweep ends, the block reports the signed distance between the two peak codes (test minus control) and a sign flag. It also reports a concentration index, which it reads from an internal table addressed by the saturated magnitude of that distance.

The controller has five states. In IDLE it waits for `start_i`. The transition "launch" goes to SETTLE, captures the configuration and clears both channel trackers. SETTLE counts the settling cycles; the transition "settled" goes to SAMPLE. SAMPLE lets both trackers take a reading. From SAMPLE, "advance" goes to STEP when the end code has not yet been sampled, and "finish" goes to DONE when it has. STEP increments the code; "resettle" goes back to SETTLE. DONE raises the done pulse; "release" returns to IDLE.

Top module: `sweep_peak_tracker`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0, both peak outputs are 0, `shift_o` is 0 and `conc_idx_o` is 0. A `start_i` pulse in IDLE sets `busy_o` and puts `code_start_i` on `freq_code_o`.
- R2: Each code is held for `settle_i`+1 cycles in SETTLE, then for one cycle in SAMPLE. The code then rises by exactly one. For N codes, `done_o` rises N*(`settle_i`+3)-1 cycles after the edge that accepted `start_i`.
- R3: The sweep ends after the code equal to `code_end_i` has been sampled. `done_o` is high for exactly one cycle, and `busy_o` is 0 in the following cycle.
- R4: A channel's stored peak code changes only when its amplitude is strictly greater than that channel's stored maximum, so a tie keeps the earlier code. The first sample of each sweep always loads, even when the amplitude is 0.
- R5: The two channels are tracked independently in the same sweep. Each peak output depends only on its own amplitude input.
- R6: A `start_i` pulse while `busy_o` is 1 is ignored. Configuration inputs that change mid-sweep have no effect, because start code, end code and settle count are captured at launch.
- R7: `shift_o` = `peak_test_o` - `peak_ctrl_o` as a signed value. `shift_neg_o` is 1 exactly when that value is negative.
- R8: `conc_idx_o` = T[k], where k = min(|shift| >> LUT_SHIFT, LUT_DEPTH-1) and T[k] = k*(k+1). With the defaults, LUT_SHIFT = 2 and LUT_DEPTH = 16.
- R9: Accepting `start_i` clears both peak registers and both maxima. In the cycle after launch, both peak outputs read 0.
- R10: When the start code equals the end code, the sweep samples exactly one code, and both peaks equal that code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch pulse, accepted only in IDLE |
| code_start_i | input | CODE_W | First code of the sweep |
| code_end_i | input | CODE_W | Last code of the sweep |
| settle_i | input | SET_W | Settling count per code |
| amp_test_i | input | AMP_W | Test-channel amplitude reading |
| amp_ctrl_i | input | AMP_W | Control-channel amplitude reading |
| freq_code_o | output | CODE_W | Frequency code to the oscillator/DAC |
| busy_o | output | 1 | Sweep in progress (any state but IDLE) |
| done_o | output | 1 | One-cycle end-of-sweep pulse |
| peak_test_o | output | CODE_W | Test-channel peak code |
| peak_ctrl_o | output | CODE_W | Control-channel peak code |
| shift_o | output | CODE_W+1 | Signed peak difference, test minus control |
| shift_neg_o | output | 1 | Sign of the difference |
| conc_idx_o | output | CONC_W | Mapped concentration index |

## Verification
The bench builds the block with its default parameters: 10-bit codes, 12-bit amplitudes, a 16-entry table and a shift of 2. With these values, any peak distance of 60 or more reaches the last table entry, and a 256-code sweep stays short. The amplitude inputs come from per-code response tables in the bench, so each scenario places peaks, ties and flat responses at chosen codes. The short settle counts make the exact done latency cheap to check.

// File: rtl/spt_pkg.sv
package spt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_SAMPLE,
        ST_STEP,
        ST_DONE
    } spt_state_e;

    // Concentration curve placed in the lookup table: entry k holds k*(k+1).
    function automatic int unsigned conc_entry(int unsigned k);
        return k * (k + 1);
    endfunction

endpackage

// File: rtl/spt_sweep_ctrl.sv
module spt_sweep_ctrl #(
    parameter int CODE_W = 10,
    parameter int SET_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CODE_W-1:0] cfg_start_i,
    input  logic [CODE_W-1:0] cfg_end_i,
    input  logic [SET_W-1:0]  cfg_settle_i,
    output logic [CODE_W-1:0] code_o,
    output logic              sample_o,
    output logic              clear_o,
    output logic              busy_o,
    output logic              done_o
);
    import spt_pkg::*;

    localparam logic [CODE_W-1:0] CODE_ONE = CODE_W'(1);
    localparam logic [SET_W-1:0]  CNT_ONE  = SET_W'(1);

    spt_state_e        state_q, state_d;
    logic [CODE_W-1:0] code_q, end_q;
    logic [SET_W-1:0]  cnt_q, settle_q;
    logic              launch;

    assign launch = (state_q == ST_IDLE) && start_i;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_SETTLE;
            ST_SETTLE: if (cnt_q == settle_q) state_d = ST_SAMPLE;
            ST_SAMPLE: state_d = (code_q == end_q) ? ST_DONE : ST_STEP;
            ST_STEP:   state_d = ST_SETTLE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        busy_o   = (state_q != ST_IDLE);
        done_o   = (state_q == ST_DONE);
        sample_o = (state_q == ST_SAMPLE);
        clear_o  = launch;
    end

    // Sweep datapath: code, captured bounds and settle counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q   <= '0;
            end_q    <= '0;
            settle_q <= '0;
            cnt_q    <= '0;
        end else if (launch) begin
            code_q   <= cfg_start_i;
            end_q    <= cfg_end_i;
            settle_q <= cfg_settle_i;
            cnt_q    <= '0;
        end else if (state_q == ST_SETTLE) begin
            if (cnt_q != settle_q) cnt_q <= cnt_q + CNT_ONE;
        end else if (state_q == ST_STEP) begin
            code_q <= code_q + CODE_ONE;
            cnt_q  <= '0;
        end
    end

    assign code_o = code_q;

    AST_SETTLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_SETTLE |=> code_q == $past(code_q)); // R2
    AST_STEP_INC: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_STEP |=> code_q == $past(code_q) + CODE_ONE); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && !busy_o); // R3
    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAMPLE && start_i) |=> code_q == $past(code_q) && state_q != ST_IDLE); // R6

endmodule

// File: rtl/spt_peak_track.sv
module spt_peak_track #(
    parameter int CODE_W = 10,
    parameter int AMP_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              smp_i,
    input  logic [AMP_W-1:0]  amp_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] peak_o
);
    logic [AMP_W-1:0]  max_q;
    logic [CODE_W-1:0] peak_q;
    logic              have_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            max_q  <= '0;
            peak_q <= '0;
            have_q <= 1'b0;
        end else if (clr_i) begin
            max_q  <= '0;
            peak_q <= '0;
            have_q <= 1'b0;
        end else if (smp_i) begin
            have_q <= 1'b1;
            if (!have_q || (amp_i > max_q)) begin
                max_q  <= amp_i;
                peak_q <= code_i;
            end
        end
    end

    assign peak_o = peak_q;

    AST_MAX_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> max_q >= $past(max_q)); // R4
    AST_TIE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && smp_i && have_q && amp_i <= max_q) |=> $stable(peak_o)); // R4

endmodule

// File: rtl/spt_shift_map.sv
module spt_shift_map #(
    parameter int CODE_W    = 10,
    parameter int LUT_DEPTH = 16,
    parameter int LUT_SHIFT = 2,
    parameter int CONC_W    = 8
) (
    input  logic [CODE_W-1:0]        peak_test_i,
    input  logic [CODE_W-1:0]        peak_ctrl_i,
    output logic signed [CODE_W:0]   shift_o,
    output logic                     neg_o,
    output logic [CONC_W-1:0]        conc_o
);
    localparam int IDX_W = (LUT_DEPTH > 1) ? $clog2(LUT_DEPTH) : 1;
    localparam logic [CODE_W-1:0] IDX_LIMIT = CODE_W'(LUT_DEPTH - 1);

    logic signed [CODE_W:0] diff;
    logic [CODE_W-1:0]      mag, idx_raw;
    logic [IDX_W-1:0]       idx;
    logic [CONC_W-1:0]      lut [LUT_DEPTH];

    for (genvar g = 0; g < LUT_DEPTH; g++) begin : g_lut
        assign lut[g] = CONC_W'(spt_pkg::conc_entry(g));
    end

    always_comb begin
        diff    = $signed({1'b0, peak_test_i}) - $signed({1'b0, peak_ctrl_i});
        neg_o   = diff[CODE_W];
        mag     = neg_o ? CODE_W'(-diff) : CODE_W'(diff);
        idx_raw = mag >> LUT_SHIFT;
        idx     = (idx_raw > IDX_LIMIT) ? IDX_W'(LUT_DEPTH - 1) : idx_raw[IDX_W-1:0];
        conc_o  = lut[idx];
        shift_o = diff;
    end

endmodule

// File: rtl/sweep_peak_tracker.sv
module sweep_peak_tracker #(
    parameter int CODE_W    = 10,
    parameter int AMP_W     = 12,
    parameter int SET_W     = 8,
    parameter int LUT_DEPTH = 16,
    parameter int LUT_SHIFT = 2,
    parameter int CONC_W    = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [CODE_W-1:0]      code_start_i,
    input  logic [CODE_W-1:0]      code_end_i,
    input  logic [SET_W-1:0]       settle_i,
    input  logic [AMP_W-1:0]       amp_test_i,
    input  logic [AMP_W-1:0]       amp_ctrl_i,
    output logic [CODE_W-1:0]      freq_code_o,
    output logic                   busy_o,
    output logic                   done_o,
    output logic [CODE_W-1:0]      peak_test_o,
    output logic [CODE_W-1:0]      peak_ctrl_o,
    output logic signed [CODE_W:0] shift_o,
    output logic                   shift_neg_o,
    output logic [CONC_W-1:0]      conc_idx_o
);
    localparam int N_CH = 2;

    logic              sample, clear;
    logic [AMP_W-1:0]  amp  [N_CH];
    logic [CODE_W-1:0] peak [N_CH];

    assign amp[0] = amp_test_i;
    assign amp[1] = amp_ctrl_i;

    spt_sweep_ctrl #(.CODE_W(CODE_W), .SET_W(SET_W)) i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .cfg_start_i  (code_start_i),
        .cfg_end_i    (code_end_i),
        .cfg_settle_i (settle_i),
        .code_o       (freq_code_o),
        .sample_o     (sample),
        .clear_o      (clear),
        .busy_o       (busy_o),
        .done_o       (done_o)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        spt_peak_track #(.CODE_W(CODE_W), .AMP_W(AMP_W)) i_trk (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (clear),
            .smp_i  (sample),
            .amp_i  (amp[c]),
            .code_i (freq_code_o),
            .peak_o (peak[c])
        );
    end

    assign peak_test_o = peak[0];
    assign peak_ctrl_o = peak[1];

    spt_shift_map #(.CODE_W(CODE_W), .LUT_DEPTH(LUT_DEPTH),
                    .LUT_SHIFT(LUT_SHIFT), .CONC_W(CONC_W)) i_map (
        .peak_test_i (peak[0]),
        .peak_ctrl_i (peak[1]),
        .shift_o     (shift_o),
        .neg_o       (shift_neg_o),
        .conc_o      (conc_idx_o)
    );

endmodule

// File: tb/test_sweep_peak_tracker.sv
module test_sweep_peak_tracker;
    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [9:0]        code_start_i = '0;
    logic [9:0]        code_end_i = '0;
    logic [7:0]        settle_i = '0;
    logic [11:0]       amp_test_i, amp_ctrl_i;
    logic [9:0]        freq_code_o, peak_test_o, peak_ctrl_o;
    logic              busy_o, done_o, shift_neg_o;
    logic signed [10:0] shift_o;
    logic [7:0]        conc_idx_o;

    logic [11:0] rt [1024];
    logic [11:0] rc [1024];

    int n_checks = 0;
    int n_fail = 0;

    assign amp_test_i = rt[freq_code_o];
    assign amp_ctrl_i = rc[freq_code_o];

    always #(CLK_PERIOD/2) clk = ~clk;

    sweep_peak_tracker i_sweep_peak_tracker (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .code_start_i(code_start_i), .code_end_i(code_end_i), .settle_i(settle_i),
        .amp_test_i(amp_test_i), .amp_ctrl_i(amp_ctrl_i),
        .freq_code_o(freq_code_o), .busy_o(busy_o), .done_o(done_o),
        .peak_test_o(peak_test_o), .peak_ctrl_o(peak_ctrl_o),
        .shift_o(shift_o), .shift_neg_o(shift_neg_o), .conc_idx_o(conc_idx_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic fill(input int vt, input int vc);
        for (int c = 0; c < 1024; c++) begin
            rt[c] = 12'(vt);
            rc[c] = 12'(vc);
        end
    endtask

    // Runs one sweep and checks timing, clearing, peaks and mapping.
    task automatic run_sweep(input int s, input int e, input int st,
                             input bit inject, input string req);
        int pt, pc, mt, mc, n, cnt, d, mag, k;
        pt = 0; pc = 0; mt = 0; mc = 0;
        for (int c = s; c <= e; c++) begin
            if (c == s || int'(rt[c]) > mt) begin mt = int'(rt[c]); pt = c; end
            if (c == s || int'(rc[c]) > mc) begin mc = int'(rc[c]); pc = c; end
        end
        n = e - s + 1;
        @(negedge clk);
        code_start_i = 10'(s); code_end_i = 10'(e); settle_i = 8'(st);
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        check("R9", "peak_test cleared", int'(peak_test_o), 0);
        check("R9", "peak_ctrl cleared", int'(peak_ctrl_o), 0);
        check("R1", "busy after launch", int'(busy_o), 1);
        check("R1", "first code", int'(freq_code_o), s);
        cnt = 0;
        while (!done_o && cnt < 100000) begin
            @(negedge clk);
            cnt++;
            if (inject && cnt == 3) begin
                start_i = 1'b1; code_start_i = 10'(s + 7); code_end_i = 10'(e + 9);
                settle_i = 8'(st + 4);
            end
            if (inject && cnt == 4) start_i = 1'b0;
        end
        check(inject ? "R6" : "R2", "done latency", cnt, n * (st + 3) - 1);
        check("R4", "peak_test", int'(peak_test_o), pt);
        check("R5", "peak_ctrl", int'(peak_ctrl_o), pc);
        d = pt - pc;
        mag = (d < 0) ? -d : d;
        k = mag >> 2;
        if (k > 15) k = 15;
        check("R7", "shift", int'(shift_o), d);
        check("R7", "sign", int'(shift_neg_o), (d < 0) ? 1 : 0);
        check("R8", "conc index", int'(conc_idx_o), k * (k + 1));
        check(req, "peak_test scenario", int'(peak_test_o), pt);
        @(negedge clk);
        check("R3", "done one cycle", int'(done_o), 0);
        check("R3", "idle after done", int'(busy_o), 0);
    endtask

    task automatic t_reset();
        check("R1", "busy at reset", int'(busy_o), 0);
        check("R1", "done at reset", int'(done_o), 0);
        check("R1", "peak_test at reset", int'(peak_test_o), 0);
        check("R1", "peak_ctrl at reset", int'(peak_ctrl_o), 0);
        check("R1", "shift at reset", int'(shift_o), 0);
        check("R1", "conc at reset", int'(conc_idx_o), 0);
    endtask

    task automatic t_basic();
        fill(100, 100);
        rt[120] = 900; rc[110] = 800;
        run_sweep(100, 130, 3, 1'b0, "R5");
        check("R7", "positive shift", int'(shift_o), 10);
        check("R8", "conc for 10", int'(conc_idx_o), 6);
    endtask

    task automatic t_tie_negative();
        fill(50, 50);
        rt[118] = 500; rt[125] = 500; rt[130] = 499;
        rc[140] = 700;
        run_sweep(110, 150, 0, 1'b0, "R4");
        check("R4", "tie keeps earliest", int'(peak_test_o), 118);
        check("R7", "negative shift", int'(shift_o), -22);
        check("R8", "conc for 22", int'(conc_idx_o), 30);
    endtask

    task automatic t_saturate();
        fill(10, 10);
        rt[10] = 3000; rc[200] = 3000;
        run_sweep(0, 255, 0, 1'b0, "R8");
        check("R8", "saturated index", int'(conc_idx_o), 240);
    endtask

    task automatic t_flat();
        fill(0, 0);
        run_sweep(50, 60, 1, 1'b0, "R4");
        check("R4", "zero amplitude first load", int'(peak_ctrl_o), 50);
    endtask

    task automatic t_single();
        fill(5, 9);
        run_sweep(777, 777, 5, 1'b0, "R10");
        check("R10", "single peak_ctrl", int'(peak_ctrl_o), 777);
    endtask

    task automatic t_busy_start();
        fill(20, 20);
        rt[303] = 400; rc[301] = 400;
        run_sweep(300, 310, 2, 1'b1, "R6");
        check("R6", "shift unaffected", int'(shift_o), 2);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        fill(0, 0);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_basic();
        t_tie_negative();
        t_saturate();
        t_flat();
        t_single();
        t_busy_start();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule